// File: doc/BRIEF.md
# Debug Serial Link Master

This block drives the host side of a full-duplex synchronous debug link. It makes the serial clock from the system clock through a programmable half-period divider. In each frame it shifts a 17-bit word out to the target and shifts the target's 17-bit answer in at the same time, one bit each way per serial clock period.

A request is a 16-bit payload with a one-cycle start strobe. The block builds the outgoing word by putting a zero flag bit above the payload. It sends the word flag first, down to data bit 0. After the 17th rising serial clock edge it returns the received flag bit and the 16-bit received data, and it pulses a done strobe. Between frames the serial clock rests high.

Top module: `dbg_link_master`

## Requirements
- R1: While reset is held and after it is released, `ser_clk_o` is 1 and `busy_o`, `done_o`, `ser_out_o`, `rsp_flag_o` and `rsp_data_o` are all 0.
- R2: Each frame sends exactly 17 bits, most significant first. Bit 16, the flag bit, is always 0 and is sent first. It is followed by `req_data_i[15]` down to `req_data_i[0]`.
- R3: `ser_out_o` changes only at the system clock edge where `ser_clk_o` falls. It never changes while `ser_clk_o` stays high.
- R4: Incoming bits are captured at each rising serial clock edge. The first bit captured goes to `rsp_flag_o`. The following 16 bits fill `rsp_data_o` from bit 15 down to bit 0.
- R5: Each half-period of `ser_clk_o` lasts D system clocks, where D is `half_div_i` if it is nonzero and 1 if it is zero. The serial clock is therefore never faster than half the system clock.
- R6: `done_o` is high for exactly one system clock. It is set at the edge where the 17th rising serial edge occurs, 33·D clocks after the edge that accepted the start.
- R7: `req_start_i` is ignored while `busy_o` is high. Changes to `req_data_i` or `half_div_i` during a frame have no effect on the frame in progress.
- R8: `busy_o` is set at the edge that accepts the start and cleared D clocks after done. `ser_clk_o` is high whenever `busy_o` is low.
- R9: `rsp_flag_o` and `rsp_data_o` change only at the edge where `done_o` is set, and they hold their values until the next frame ends.
- R10: A frame has exactly 17 rising and 16 falling serial clock edges after its initial falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div_i | input | 8 | System clocks per serial half-period (0 acts as 1) |
| req_start_i | input | 1 | Start strobe, accepted only while idle |
| req_data_i | input | 16 | Payload to send |
| ser_clk_o | output | 1 | Serial clock, idles high |
| ser_out_o | output | 1 | Serial data to target |
| ser_in_i | input | 1 | Serial data from target |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame strobe |
| rsp_flag_o | output | 1 | Received status bit (bit 16) |
| rsp_data_o | output | 16 | Received data field |

## Verification
The bench drives each start at a falling system clock edge and counts rising edges from there. With that edge numbered 1, it expects `done_o` after edge 1+33·D, with the response already valid in the same cycle. It expects `busy_o` to drop after edge 1+34·D, and it checks that done is low again one cycle later. A bench target model presents each response bit after every serial falling edge, and a second monitor records `ser_out_o` at every serial rising edge. Those captures are compared with the expected words once the frame ends. All sampling happens at falling system clock edges, so no result depends on ordering at the active edge.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned FRAME_W = DATA_W + 1;
  localparam int unsigned BITS_W  = $clog2(FRAME_W + 1);
endpackage

// File: rtl/dlm_sclk_gen.sv
module dlm_sclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             last_i,
  output logic             sclk_o,
  output logic             run_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             sclk_q, sclk_d;
  logic             run_q, run_d;
  logic [DIV_W-1:0] eff_div;
  logic             tick;

  assign eff_div = (half_div_i == '0) ? DIV_W'(1) : half_div_i;
  assign tick    = run_q && (cnt_q == '0);
  assign rise_o  = tick && !sclk_q;
  assign fall_o  = tick && sclk_q && !last_i;

  always_comb begin
    cnt_d  = cnt_q;
    div_d  = div_q;
    sclk_d = sclk_q;
    run_d  = run_q;
    if (!run_q) begin
      sclk_d = 1'b1;
      if (launch_i) begin
        run_d  = 1'b1;
        sclk_d = 1'b0;
        div_d  = eff_div;
        cnt_d  = eff_div - DIV_W'(1);
      end
    end else if (tick) begin
      if (!sclk_q) begin
        sclk_d = 1'b1;
        cnt_d  = div_q - DIV_W'(1);
      end else if (!last_i) begin
        sclk_d = 1'b0;
        cnt_d  = div_q - DIV_W'(1);
      end else begin
        run_d = 1'b0;
      end
    end else begin
      cnt_d = cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      div_q  <= DIV_W'(1);
      sclk_q <= 1'b1;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      sclk_q <= sclk_d;
      run_q  <= run_d;
    end
  end

  assign sclk_o = sclk_q;
  assign run_o  = run_q;

  // R8: clock rests high outside a frame
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> sclk_q);
  // R5: counter never exceeds the latched half-period
  assert_half_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < div_q) && (div_q != '0));
  // R7: latched divider holds during a frame
  assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && $past(run_q) |-> $stable(div_q));
endmodule

// File: rtl/dlm_shifter.sv
module dlm_shifter
  import dlm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              finish_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              rsp_flag_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [FRAME_W-1:0] rx_q, rx_d;
  logic [FRAME_W-1:0] word_in;
  logic               flag_q, flag_d;
  logic [DATA_W-1:0]  data_q, data_d;

  assign word_in = {rx_q[FRAME_W-2:0], sdi_i};

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    flag_d = flag_q;
    data_d = data_q;
    if (load_i) begin
      tx_d = {1'b0, load_data_i};
      rx_d = '0;
    end else begin
      if (fall_i) tx_d = {tx_q[FRAME_W-2:0], 1'b0};
      if (rise_i) rx_d = word_in;
    end
    if (finish_i) begin
      flag_d = word_in[FRAME_W-1];
      data_d = word_in[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      flag_q <= 1'b0;
      data_q <= '0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      flag_q <= flag_d;
      data_q <= data_d;
    end
  end

  assign sdo_o      = tx_q[FRAME_W-1];
  assign rsp_flag_o = flag_q;
  assign rsp_data_o = data_q;

  // R9: response registers move only when the frame ends
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !finish_i |=> $stable(data_q) && $stable(flag_q));
  // R2: a freshly loaded word always starts with a zero flag bit
  assert_flag_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !sdo_o);
endmodule

// File: rtl/dbg_link_master.sv
module dbg_link_master
  import dlm_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div_i,
  input  logic              req_start_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              ser_clk_o,
  output logic              ser_out_o,
  input  logic              ser_in_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rsp_flag_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  logic              rst_s1_q, rst_s2_q;
  logic              run;
  logic              rise, fall;
  logic              launch;
  logic              last;
  logic              finish;
  logic [BITS_W-1:0] bits_q, bits_d;
  logic              done_q, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  assign launch = req_start_i && !run;
  assign last   = (bits_q == BITS_W'(FRAME_W));
  assign finish = rise && (bits_q == BITS_W'(FRAME_W - 1));

  always_comb begin
    bits_d = bits_q;
    done_d = finish;
    if (launch)    bits_d = '0;
    else if (rise) bits_d = bits_q + BITS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) begin
      bits_q <= '0;
      done_q <= 1'b0;
    end else begin
      bits_q <= bits_d;
      done_q <= done_d;
    end
  end

  dlm_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk       (clk),
    .rst_n     (rst_s2_q),
    .launch_i  (launch),
    .half_div_i(half_div_i),
    .last_i    (last),
    .sclk_o    (ser_clk_o),
    .run_o     (run),
    .rise_o    (rise),
    .fall_o    (fall)
  );

  dlm_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .load_i     (launch),
    .load_data_i(req_data_i),
    .rise_i     (rise),
    .fall_i     (fall),
    .finish_i   (finish),
    .sdi_i      (ser_in_i),
    .sdo_o      (ser_out_o),
    .rsp_flag_o (rsp_flag_o),
    .rsp_data_o (rsp_data_o)
  );

  assign busy_o = run;
  assign done_o = done_q;

  // R6: done lasts a single cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_s2_q)
    done_q |=> !done_q);
  // R10: never more than 17 rising edges per frame
  assert_bit_limit_R10: assert property (@(posedge clk) disable iff (!rst_s2_q)
    bits_q <= BITS_W'(FRAME_W));
  // R3: output data holds while the serial clock stays high
  assert_sdo_stable_R3: assert property (@(posedge clk) disable iff (!rst_s2_q)
    ser_clk_o && $past(ser_clk_o) |-> $stable(ser_out_o));
  // R7: a start during a frame does not restart the bit count
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_s2_q)
    busy_o && req_start_i && !rise |=> $stable(bits_q));
  // R8: busy ends only after all rising edges
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_s2_q)
    $fell(busy_o) |-> ser_clk_o && last);
endmodule

// File: tb/dbg_link_master_tb.sv
module dbg_link_master_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  half_div;
  logic        start;
  logic [15:0] tx_data;
  logic        sclk, sdo, sdi, busy, done, rflag;
  logic [15:0] rdata;

  int unsigned total = 0;
  int unsigned bad   = 0;
  int unsigned cyc   = 0;

  logic [16:0] slv_word;
  int          slv_idx;
  logic [16:0] cap;
  int          cap_n;

  always #4 clk = ~clk;

  dbg_link_master u_dut (
    .clk(clk), .rst_n(rst_n), .half_div_i(half_div), .req_start_i(start),
    .req_data_i(tx_data), .ser_clk_o(sclk), .ser_out_o(sdo), .ser_in_i(sdi),
    .busy_o(busy), .done_o(done), .rsp_flag_o(rflag), .rsp_data_o(rdata)
  );

  always @(negedge sclk) begin
    if (slv_idx < 17) begin
      sdi = slv_word[16 - slv_idx];
      slv_idx = slv_idx + 1;
    end
  end

  always @(posedge sclk) begin
    cap   = {cap[15:0], sdo};
    cap_n = cap_n + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  task automatic frame(input logic [15:0] tx, input logic [16:0] resp,
                       input int div, input bit disturb);
    int n;
    int d;
    logic [15:0] r_data;
    logic        r_flag;
    d = eff(div);
    @(negedge clk);
    slv_word = resp; slv_idx = 0; cap = '0; cap_n = 0;
    tx_data = tx; half_div = 8'(div); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    chk(busy && !sclk, "R8 busy set, clock low after start", {busy, sclk}, 2'b10);
    while (!done && n < 5000) begin
      if (disturb && n == 3) begin
        start = 1'b1; tx_data = ~tx; half_div = 8'(div + 3);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    chk(n == 1 + 33 * d, "R6 done latency", n, 1 + 33 * d);
    chk(rflag == resp[16], "R4 response flag", rflag, resp[16]);
    chk(rdata == resp[15:0], "R4 response data", rdata, resp[15:0]);
    r_data = rdata; r_flag = rflag;
    if (disturb) begin
      start = 1'b1;
    end
    @(negedge clk);
    n++;
    chk(!done, "R6 done single cycle", done, 0);
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == 1 + 34 * d, "R8 busy clears D after done", n, 1 + 34 * d);
    chk(sclk == 1'b1, "R8 clock high when idle", sclk, 1);
    chk(cap_n == 17, "R10 rising edge count", cap_n, 17);
    chk(cap == {1'b0, tx}, "R2 sent word flag zero then payload", cap, {1'b0, tx});
    repeat (3) @(negedge clk);
    chk(rdata == r_data && rflag == r_flag, "R9 response held after frame",
        {rflag, rdata}, {r_flag, r_data});
    chk(!busy, "R7 late start ignored", busy, 0);
  endtask

  task automatic sdo_watch(input logic [15:0] tx, input int div);
    logic prev_s, prev_o;
    int   viol;
    viol = 0;
    @(negedge clk);
    slv_word = 17'h1A5A5; slv_idx = 0; cap = '0; cap_n = 0;
    tx_data = tx; half_div = 8'(div); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev_s = sclk; prev_o = sdo;
    while (busy) begin
      @(negedge clk);
      if (prev_s && sclk && (sdo !== prev_o)) viol++;
      prev_s = sclk; prev_o = sdo;
    end
    chk(viol == 0, "R3 output stable while clock high", viol, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; start = 1'b0; tx_data = '0; half_div = 8'd1; sdi = 1'b0;
    slv_word = '0; slv_idx = 17; cap = '0; cap_n = 0;
    repeat (3) @(negedge clk);
    chk(sclk && !busy && !done && !sdo && !rflag && rdata == 0, "R1 state in reset",
        {sclk, busy, done, sdo, rflag, rdata}, 21'h100000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sclk && !busy && !done && !sdo && !rflag && rdata == 0, "R1 state after reset",
        {sclk, busy, done, sdo, rflag, rdata}, 21'h100000);

    frame(16'hA55A, 17'h0FFFF, 1, 1'b0);
    frame(16'hFFFF, 17'h10000, 0, 1'b0);   // R5 divider zero acts as one
    frame(16'h0001, 17'h10001, 2, 1'b1);   // R7 disturbance mid-frame
    frame(16'h8000, 17'h1FFFF, 5, 1'b0);   // R5 slower clock
    sdo_watch(16'h6C93, 3);
    for (int i = 0; i < 20; i++) begin
      frame(16'($urandom), 17'($urandom), int'($urandom % 5), 1'($urandom % 2));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule